// File: doc/BRIEF.md
# Serial Register-File Target with Auto-Incrementing Pointer

This block is a two-wire serial bus target with a 7-bit device address. It gives a bus controller byte-wide access to a 256-location register space through an internal pointer. The controller first writes the pointer. It can then stream data bytes in, or issue a repeated START and stream data bytes out. The pointer advances by one after every byte that is transferred. Both bus lines are sampled by the system clock through a short synchronizer, and the block pulls SDA low through an open-drain enable.

The register space holds a configuration byte, a window of read-only 16-bit measurement words supplied on an input port, and a window of writable bytes that drive an output port. All other locations are reserved. The configuration byte holds the low three bits of the device address, so software can move the device to another bus address. When the high byte of a 16-bit word is read, the low byte is captured at the same moment. A read of both halves inside one transaction therefore always returns a matched pair.

Top module: `i2c_regfile_slave`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 1001 followed by the address-low field of the configuration byte. It never drives SDA for any other address.
- R2: A write transaction (START, address+W, pointer byte, data bytes, STOP) stores each data byte at the pointer, and the pointer steps by one after every byte. Byte k of the writable window (base 10h) appears on rw_regs_o[8k+7:8k].
- R3: A read transaction (pointer write, repeated START, address+R) returns bytes from the pointer onward, MSB first, stepping after each byte. The master acknowledges every byte it wants continued. After the master NAKs a byte, the target keeps SDA released until the next START.
- R4: Writes to the read-only word window (0Ah-0Fh) and to reserved locations have no effect. Reserved locations read as 00h. Word w of ro_words_i reads with bits 15:8 at address 0Ah+2w and bits 7:0 at 0Bh+2w.
- R5: Once the pointer steps past FFh, further written bytes in that transaction are dropped (no wrap to 00h) and every further byte read returns FFh.
- R6: Reading the even (high) address of a 16-bit word captures its low byte. A read of the odd address within the same transaction returns the captured value even if the source has changed since. The capture is dropped at START or STOP.
- R7: The configuration byte at 01h has this layout:
  - bit 7 reads 0;
  - bit 6 is a power-up flag that resets to 1 and can only be cleared by writing 0;
  - bits 5:3 drive ctrl_o;
  - bits 2:0 are the address-low field, and a new value takes effect from the next START or repeated START.
- R8: A data byte that ends before its eighth bit is not stored.
- R9: After reset SDA is released, ctrl_o and rw_regs_o are zero, and 01h reads 40h.
- R10: The target changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, at least 20x the bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| ro_words_i | input | RO_WORDS*16 | Read-only measurement words, word 0 in the low bits |
| ctrl_o | output | 3 | Control field of the configuration byte |
| rw_regs_o | output | RW_BYTES*8 | Contents of the writable byte window |

## Verification
The bench builds the block with its defaults: three read-only words at 0Ah, four writable bytes at 10h and a two-stage synchronizer. With the 7-bit address space, the bench can sweep all 128 device addresses. The small windows let every read-only and writable location, and the boundary addresses on either side of them, be read back against values computed in the bench. Because the pointer is only eight bits wide, bursts started at FEh and FFh exercise read saturation and dropped writes after the end of the space.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;
  localparam logic [3:0] DEV_ADDR_HI = 4'b1001;
  localparam logic [7:0] CFG_ADDR    = 8'h01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_MADDR,
    ST_MADDR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } proto_state_e;
endpackage

// File: rtl/i2cr_line_sync.sv
module i2cr_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_d;
  assign scl_fall_o = ~scl_o & scl_d;
  // data edges with clock held high
  assign start_o    = scl_o & scl_d & sda_d & ~sda_o;
  assign stop_o     = scl_o & scl_d & ~sda_d & sda_o;
endmodule

// File: rtl/i2cr_proto.sv
module i2cr_proto
  import i2cr_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic       scl_rise_i,
  input  logic       scl_fall_i,
  input  logic       start_i,
  input  logic       stop_i,
  input  logic [2:0] addr_lo_i,
  input  logic [7:0] rd_byte_i,
  output logic       sda_oe_o,
  output logic [7:0] ptr_o,
  output logic       ptr_ovf_o,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o,
  output logic       rd_load_o,
  output logic       txn_clear_o
);
  proto_state_e state_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] rx_q, tx_q, ptr_q;
  logic byte_full_q, rw_q, m_ack_q, sda_oe_q, ptr_ovf_q;
  logic bus_evt, rx_state, addr_hit, ptr_inc;

  assign bus_evt  = start_i | stop_i;
  assign rx_state = state_q inside {ST_ADDR, ST_MADDR, ST_WDATA};
  assign addr_hit = rx_q[7:1] == {DEV_ADDR_HI, addr_lo_i};

  assign rd_load_o = !bus_evt && scl_fall_i &&
                     ((state_q == ST_ADDR_ACK && rw_q) || (state_q == ST_RACK && m_ack_q));
  assign wr_en_o   = !bus_evt && scl_fall_i && state_q == ST_WDATA && byte_full_q && !ptr_ovf_q;
  assign ptr_inc   = !bus_evt && scl_fall_i &&
                     ((state_q == ST_WDATA && byte_full_q) ||
                      (state_q == ST_RDATA && bit_cnt_q == 3'd7));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      bit_cnt_q   <= '0;
      rx_q        <= '0;
      tx_q        <= '0;
      ptr_q       <= '0;
      byte_full_q <= 1'b0;
      rw_q        <= 1'b0;
      m_ack_q     <= 1'b0;
      sda_oe_q    <= 1'b0;
      ptr_ovf_q   <= 1'b0;
    end else if (start_i) begin
      state_q     <= ST_ADDR;
      bit_cnt_q   <= '0;
      byte_full_q <= 1'b0;
      sda_oe_q    <= 1'b0;
    end else if (stop_i) begin
      state_q     <= ST_IDLE;
      byte_full_q <= 1'b0;
      sda_oe_q    <= 1'b0;
    end else begin
      if (scl_rise_i) begin
        if (rx_state) begin
          rx_q        <= {rx_q[6:0], sda_i};
          bit_cnt_q   <= bit_cnt_q + 3'd1;
          byte_full_q <= bit_cnt_q == 3'd7;
        end
        if (state_q == ST_RACK) m_ack_q <= !sda_i;
      end
      if (ptr_inc) begin
        ptr_q <= ptr_q + 8'd1;
        if (ptr_q == 8'hFF) ptr_ovf_q <= 1'b1;
      end
      if (rd_load_o) begin
        tx_q      <= rd_byte_i;
        sda_oe_q  <= !rd_byte_i[7];
        bit_cnt_q <= '0;
        state_q   <= ST_RDATA;
      end else if (scl_fall_i) begin
        case (state_q)
          ST_ADDR: if (byte_full_q) begin
            byte_full_q <= 1'b0;
            if (addr_hit) begin
              sda_oe_q <= 1'b1;
              rw_q     <= rx_q[0];
              state_q  <= ST_ADDR_ACK;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
          ST_MADDR: if (byte_full_q) begin
            byte_full_q <= 1'b0;
            sda_oe_q    <= 1'b1;
            ptr_q       <= rx_q;
            ptr_ovf_q   <= 1'b0;
            state_q     <= ST_MADDR_ACK;
          end
          ST_WDATA: if (byte_full_q) begin
            byte_full_q <= 1'b0;
            sda_oe_q    <= 1'b1;
            state_q     <= ST_WDATA_ACK;
          end
          ST_ADDR_ACK: begin
            sda_oe_q  <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_MADDR;
          end
          ST_MADDR_ACK, ST_WDATA_ACK: begin
            sda_oe_q  <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= ST_WDATA;
          end
          ST_RDATA: if (bit_cnt_q == 3'd7) begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_RACK;
          end else begin
            tx_q      <= {tx_q[6:0], 1'b0};
            sda_oe_q  <= !tx_q[6];
            bit_cnt_q <= bit_cnt_q + 3'd1;
          end
          ST_RACK: begin
            sda_oe_q <= 1'b0;
            state_q  <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = sda_oe_q;
  assign ptr_o       = ptr_q;
  assign ptr_ovf_o   = ptr_ovf_q;
  assign wr_data_o   = rx_q;
  assign txn_clear_o = bus_evt;

  // R10: drive only asserted during clock low
  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_i);
  // R1: idle target never holds the line
  a_r1_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_IDLE |-> !sda_oe_q);
  // R2: pointer steps by exactly one per transferred byte
  a_r2_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_inc |=> ptr_q == 8'($past(ptr_q) + 8'd1));
  // R5: once past the end, overflow stays until a new pointer byte
  a_r5_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_ovf_q && !(scl_fall_i && state_q == ST_MADDR) |=> ptr_ovf_q);
endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs
  import i2cr_pkg::*;
#(
  parameter int RO_BASE  = 10,
  parameter int RO_WORDS = 3,
  parameter int RW_BASE  = 16,
  parameter int RW_BYTES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [7:0]              addr_i,
  input  logic                    ovf_i,
  input  logic [7:0]              wr_data_i,
  input  logic                    rd_load_i,
  input  logic                    clear_i,
  input  logic [RO_WORDS*16-1:0]  ro_words_i,
  output logic [7:0]              rd_byte_o,
  output logic [2:0]              addr_lo_o,
  output logic [2:0]              ctrl_o,
  output logic [RW_BYTES*8-1:0]   rw_regs_o
);
  localparam int RO_BYTES = 2 * RO_WORDS;
  localparam logic [8:0] RO_LO = 9'(RO_BASE);
  localparam logic [8:0] RO_HI = 9'(RO_BASE + RO_BYTES);
  localparam logic [8:0] RW_LO = 9'(RW_BASE);
  localparam logic [8:0] RW_HI = 9'(RW_BASE + RW_BYTES);

  logic [7:0] ro_bytes [RO_BYTES];
  logic [7:0] rw_q     [RW_BYTES];
  logic       por_q, snap_valid_q, in_words;
  logic [2:0] ctrl_q, addr_lo_q;
  logic [7:0] addr_p1, cfg_byte, raw_byte, nxt_byte, snap_addr_q, snap_byte_q;

  for (genvar w = 0; w < RO_WORDS; w++) begin : g_ro
    assign ro_bytes[2*w]   = ro_words_i[16*w+8 +: 8];
    assign ro_bytes[2*w+1] = ro_words_i[16*w   +: 8];
  end

  for (genvar b = 0; b < RW_BYTES; b++) begin : g_rw_out
    assign rw_regs_o[8*b +: 8] = rw_q[b];
  end

  assign addr_p1  = addr_i + 8'd1;
  assign cfg_byte = {1'b0, por_q, ctrl_q, addr_lo_q};
  assign in_words = !addr_i[0] &&
                    (({1'b0, addr_i} >= RO_LO && {1'b0, addr_i} < RO_HI) ||
                     ({1'b0, addr_i} >= RW_LO && {1'b0, addr_i} < RW_HI));

  always_comb begin
    raw_byte = (addr_i == CFG_ADDR) ? cfg_byte : 8'h00;
    nxt_byte = 8'h00;
    for (int i = 0; i < RO_BYTES; i++) begin
      if (addr_i  == 8'(RO_BASE + i)) raw_byte = ro_bytes[i];
      if (addr_p1 == 8'(RO_BASE + i)) nxt_byte = ro_bytes[i];
    end
    for (int i = 0; i < RW_BYTES; i++) begin
      if (addr_i  == 8'(RW_BASE + i)) raw_byte = rw_q[i];
      if (addr_p1 == 8'(RW_BASE + i)) nxt_byte = rw_q[i];
    end
  end

  assign rd_byte_o = ovf_i ? 8'hFF :
                     (snap_valid_q && addr_i == snap_addr_q) ? snap_byte_q : raw_byte;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      snap_valid_q <= 1'b0;
      snap_addr_q  <= '0;
      snap_byte_q  <= '0;
    end else if (clear_i) begin
      snap_valid_q <= 1'b0;
    end else if (rd_load_i && !ovf_i && in_words) begin
      snap_valid_q <= 1'b1;
      snap_addr_q  <= addr_p1;
      snap_byte_q  <= nxt_byte;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      por_q     <= 1'b1;
      ctrl_q    <= '0;
      addr_lo_q <= '0;
      for (int i = 0; i < RW_BYTES; i++) rw_q[i] <= '0;
    end else if (wr_en_i) begin
      if (addr_i == CFG_ADDR) begin
        por_q     <= por_q & wr_data_i[6];
        ctrl_q    <= wr_data_i[5:3];
        addr_lo_q <= wr_data_i[2:0];
      end
      for (int i = 0; i < RW_BYTES; i++)
        if (addr_i == 8'(RW_BASE + i)) rw_q[i] <= wr_data_i;
    end
  end

  assign addr_lo_o = addr_lo_q;
  assign ctrl_o    = ctrl_q;

  // R7: flag can be cleared but never set again
  a_r7_por_sticky_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !por_q |=> !por_q);
  // R6: captured byte is frozen until a bus event or a new load
  a_r6_snap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snap_valid_q && !clear_i && !rd_load_i |=> snap_valid_q && $stable(snap_byte_q));
  // R4: read-only window never alters writable state
  a_r4_ro_write_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && {1'b0, addr_i} >= RO_LO && {1'b0, addr_i} < RO_HI |=> $stable(rw_regs_o));
endmodule

// File: rtl/i2c_regfile_slave.sv
module i2c_regfile_slave #(
  parameter int RO_BASE     = 10,
  parameter int RO_WORDS    = 3,
  parameter int RW_BASE     = 16,
  parameter int RW_BYTES    = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe_o,
  input  logic [RO_WORDS*16-1:0] ro_words_i,
  output logic [2:0]             ctrl_o,
  output logic [RW_BYTES*8-1:0]  rw_regs_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start, stop;
  logic [2:0] addr_lo;
  logic [7:0] rd_byte, ptr, wr_data;
  logic ptr_ovf, wr_en, rd_load, txn_clear;

  i2cr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start),
    .stop_o     (stop)
  );

  i2cr_proto u_proto (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .scl_i       (scl_s),
    .sda_i       (sda_s),
    .scl_rise_i  (scl_rise),
    .scl_fall_i  (scl_fall),
    .start_i     (start),
    .stop_i      (stop),
    .addr_lo_i   (addr_lo),
    .rd_byte_i   (rd_byte),
    .sda_oe_o    (sda_oe_o),
    .ptr_o       (ptr),
    .ptr_ovf_o   (ptr_ovf),
    .wr_en_o     (wr_en),
    .wr_data_o   (wr_data),
    .rd_load_o   (rd_load),
    .txn_clear_o (txn_clear)
  );

  i2cr_regs #(
    .RO_BASE  (RO_BASE),
    .RO_WORDS (RO_WORDS),
    .RW_BASE  (RW_BASE),
    .RW_BYTES (RW_BYTES)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .addr_i     (ptr),
    .ovf_i      (ptr_ovf),
    .wr_data_i  (wr_data),
    .rd_load_i  (rd_load),
    .clear_i    (txn_clear),
    .ro_words_i (ro_words_i),
    .rd_byte_o  (rd_byte),
    .addr_lo_o  (addr_lo),
    .ctrl_o     (ctrl_o),
    .rw_regs_o  (rw_regs_o)
  );
endmodule

// File: tb/tb_i2c_regfile_slave.sv
module tb_i2c_regfile_slave;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, sda_line;
  logic [47:0] ro_words = 48'h8001_7F3E_1234;
  logic [2:0]  ctrl;
  logic [31:0] rw_regs;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regfile_slave dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe),
    .ro_words_i (ro_words),
    .ctrl_o     (ctrl),
    .rw_regs_o  (rw_regs)
  );

  int checks = 0, errors = 0, viol = 0;
  logic [6:0] dev = 7'h48;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  // R10 monitor: drive must not move during clock high
  always @(posedge clk) begin
    #5;
    if (rst_n && scl_m && scl_prev && sda_oe !== oe_prev) viol++;
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = !sda_line; wq(); scl_m = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic get_byte(input logic ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
      repeat (2) @(negedge clk);
    end
    sda_m = !ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0;
    repeat (2) @(negedge clk);
    sda_m = 1'b1;
  endtask

  task automatic reg_write(input logic [7:0] maddr, input int n);
    logic a;
    bus_start();
    put_byte({dev, 1'b0}, a);
    put_byte(maddr, a);
    for (int i = 0; i < n; i++) put_byte(wbuf[i], a);
    bus_stop();
  endtask

  task automatic reg_read(input logic [7:0] maddr, input int n);
    logic a;
    bus_start();
    put_byte({dev, 1'b0}, a);
    put_byte(maddr, a);
    bus_start();
    put_byte({dev, 1'b1}, a);
    for (int i = 0; i < n; i++) get_byte(i != n - 1, rbuf[i]);
    bus_stop();
  endtask

  function automatic logic [7:0] ro_exp(input int idx);
    return ro_words[16*(idx/2) + ((idx % 2) ? 0 : 8) +: 8];
  endfunction

  initial begin
    logic a;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9 reset state
    check("R9 sda released", 32'(sda_oe), 32'h0);
    check("R9 ctrl", 32'(ctrl), 32'h0);
    check("R9 rw window", rw_regs, 32'h0);
    reg_read(8'h01, 1);
    check("R9 R7 config reset", 32'(rbuf[0]), 32'h40);

    // R1 sweep every device address
    for (int d = 0; d < 128; d++) begin
      bus_start();
      put_byte({7'(d), 1'b0}, a);
      bus_stop();
      check($sformatf("R1 addr %02h", d), 32'(a), 32'(d == 8'h48));
    end

    // R2 burst write, R3 burst read back
    wbuf[0] = 8'hA5; wbuf[1] = 8'h5A; wbuf[2] = 8'h3C; wbuf[3] = 8'hC3;
    reg_write(8'h10, 4);
    check("R2 rw window", rw_regs, 32'hC33C_5AA5);
    reg_read(8'h10, 4);
    for (int i = 0; i < 4; i++) check("R3 rw readback", 32'(rbuf[i]), 32'(wbuf[i]));

    // R3 R4 read-only window sweep
    reg_read(8'h0A, 6);
    for (int i = 0; i < 6; i++) check("R4 ro read", 32'(rbuf[i]), 32'(ro_exp(i)));

    // R4 writes to read-only and reserved locations
    wbuf[0] = 8'h00; wbuf[1] = 8'h00;
    reg_write(8'h0A, 2);
    reg_read(8'h0A, 2);
    check("R4 ro write ignored msb", 32'(rbuf[0]), 32'(ro_exp(0)));
    check("R4 ro write ignored lsb", 32'(rbuf[1]), 32'(ro_exp(1)));
    wbuf[0] = 8'h77;
    reg_write(8'h00, 1);
    reg_write(8'h20, 1);
    reg_read(8'h00, 1);
    check("R4 reserved 00", 32'(rbuf[0]), 32'h0);
    reg_read(8'h20, 1);
    check("R4 reserved 20", 32'(rbuf[0]), 32'h0);
    reg_read(8'h14, 1);
    check("R4 reserved 14", 32'(rbuf[0]), 32'h0);
    check("R4 rw untouched", rw_regs, 32'hC33C_5AA5);

    // R5 read past the end saturates
    reg_read(8'hFE, 4);
    check("R5 read FE", 32'(rbuf[0]), 32'h00);
    check("R5 read FF", 32'(rbuf[1]), 32'h00);
    check("R5 past end 0", 32'(rbuf[2]), 32'hFF);
    check("R5 past end 1", 32'(rbuf[3]), 32'hFF);
    // R5 write past the end does not wrap into 00h/01h
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h3F;
    reg_write(8'hFF, 3);
    reg_read(8'h01, 1);
    check("R5 no wrap config", 32'(rbuf[0]), 32'h40);
    check("R5 no wrap ctrl", 32'(ctrl), 32'h0);

    // R6 snapshot of low byte at high-byte read
    bus_start();
    put_byte({dev, 1'b0}, a);
    put_byte(8'h0A, a);
    bus_start();
    put_byte({dev, 1'b1}, a);
    get_byte(1'b1, b);
    check("R6 msb", 32'(b), 32'h12);
    ro_words[15:0] = 16'hABCD;
    get_byte(1'b0, b);
    check("R6 lsb captured", 32'(b), 32'h34);
    check("R3 released after nak", 32'(sda_oe), 32'h0);
    repeat (20) @(negedge clk);
    check("R3 still released", 32'(sda_oe), 32'h0);
    bus_stop();
    reg_read(8'h0B, 1);
    check("R6 lsb live after stop", 32'(rbuf[0]), 32'hCD);

    // R8 incomplete byte dropped
    bus_start();
    put_byte({dev, 1'b0}, a);
    put_byte(8'h10, a);
    for (int i = 0; i < 5; i++) put_bit(1'b0);
    bus_stop();
    check("R8 partial byte", rw_regs, 32'hC33C_5AA5);

    // R7 config: ctrl field, address move, flag write-to-zero
    wbuf[0] = 8'h7D;
    reg_write(8'h01, 1);
    check("R7 ctrl", 32'(ctrl), 32'h7);
    bus_start();
    put_byte({7'h48, 1'b1}, a);
    bus_stop();
    check("R7 R1 old address nak", 32'(a), 32'h0);
    dev = 7'h4D;
    reg_read(8'h01, 1);
    check("R7 config new address", 32'(rbuf[0]), 32'h7D);
    wbuf[0] = 8'h00;
    reg_write(8'h01, 1);
    dev = 7'h48;
    reg_read(8'h01, 1);
    check("R7 flag cleared", 32'(rbuf[0]), 32'h00);
    wbuf[0] = 8'h40;
    reg_write(8'h01, 1);
    reg_read(8'h01, 1);
    check("R7 flag not settable", 32'(rbuf[0]), 32'h00);

    check("R10 drive moved with clock high", 32'(viol), 32'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule